// File: doc/BRIEF.md
# Set-Associative Tag Directory with Selectable Replacement

This block decides, for every incoming address, whether the addressed block is already resident in a set-associative cache, and keeps the resident set up to date. No data is stored: each way holds only a tag and a valid flag. An address is cut into a block offset, a set index and a tag. The tag is compared against every way of the indexed set in a single cycle.

On a miss the line is filled at once. A free way is always used first. Only when the whole set is valid does the selected replacement policy choose the victim. The policies are least-recently-used, first-in-first-out and pseudo-random. LRU uses per-set generation stamps. FIFO order advances only on fills. The random policy draws from a free-running shift register.

The result of each request (hit flag and way used) appears one cycle after the request. The access and miss totals are updated in the same cycle as that result. A request that follows another in the next cycle sees the state the earlier one left behind.

Top module: `cache_tag_dir`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0 and both totals read 0. All lines are invalid, so the first access to any set misses.
- R2: With the default geometry (32-bit address, 64-byte blocks, 32 sets, 8 ways), the set index is address bits [10:6] and the tag is bits [31:11]. Bits [5:0] have no effect on the hit decision.
- R3: A request with `req_valid`=1 produces `rsp_valid`=1 in the next cycle, and no other cycle has `rsp_valid`=1. `rsp_hit`=1 only when a valid way of the indexed set holds the request tag, and `rsp_way` then names that way.
- R4: On a miss, the lowest-numbered invalid way of the set is filled, whatever the policy, and `rsp_way` names it.
- R5: With `policy_sel` = 0 (code 3 behaves the same), every hit and every fill stamps the way with the set's generation count, which then increments. A conflict miss replaces the way with the smallest stamp.
- R6: With `policy_sel` = 1, hits leave the replacement order untouched. Conflict misses replace ways in the order in which they were filled, oldest first.
- R7: With `policy_sel` = 2, a conflict miss replaces a way given by the low bits of a free-running pseudo-random sequence. The replaced line's tag then misses, and the new tag hits in the reported way.
- R8: `access_count` increments by one for every request and `miss_count` by one for every miss. Both hold steady in idle cycles.
- R9: A request issued in the cycle right after another request to the same set observes that earlier request's fill or update.
- R10: Fills and policy state of one set do not disturb any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, one lookup per cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| policy_sel | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 random, 3 LRU |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | 1 on hit, 0 on miss (line was filled) |
| rsp_way | output | $clog2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Total requests since reset |
| miss_count | output | CNT_W | Total misses since reset |

## Verification
On every cycle, the assertions check the following:
- the one-cycle request/response pairing;
- that at most one way matches;
- that a free way is taken whenever one exists;
- that FIFO order is untouched by hits;
- that the generation count never wraps;
- that the random source never locks at zero;
- that the totals step exactly with requests and misses.

Which way a policy evicts after a particular history can be shown only by the directed scenarios. Each scenario fills a set, perturbs it with hits and then forces conflict misses. The same holds for offset independence, set isolation and back-to-back visibility.

// File: rtl/ctd_pkg.sv
package ctd_pkg;
  typedef enum logic [1:0] {
    POL_LRU  = 2'd0,
    POL_FIFO = 2'd1,
    POL_RAND = 2'd2,
    POL_ALT  = 2'd3
  } policy_e;
endpackage

// File: rtl/ctd_lfsr.sv
module ctd_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [15:0] value
);
  logic [15:0] lfsr_q;
  logic [15:0] lfsr_d;

  always_comb begin
    lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else        lfsr_q <= lfsr_d;
  end

  assign value = lfsr_q;

  // R7: the random source must never fall into the all-zero lock state
  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 16'd0);
endmodule

// File: rtl/ctd_way_match.sv
module ctd_way_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 21,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        chk_en,
  input  logic [WAYS-1:0]             way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        any_free,
  output logic [WAY_W-1:0]            free_way
);
  logic [WAYS-1:0] match_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match_vec[g] = way_valid[g] && (way_tag[g] == look_tag);
  end

  always_comb begin
    hit      = |match_vec;
    any_free = ~&way_valid;
    hit_way  = '0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match_vec[i])  hit_way  = WAY_W'(i);
      if (!way_valid[i]) free_way = WAY_W'(i);
    end
  end

  // R3: a tag may be resident in at most one way of a set
  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot0(match_vec));
endmodule

// File: rtl/ctd_lru_pick.sv
module ctd_lru_pick #(
  parameter int WAYS    = 8,
  parameter int STAMP_W = 24,
  localparam int WAY_W  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][STAMP_W-1:0] stamps,
  output logic [WAY_W-1:0]             victim
);
  logic [STAMP_W-1:0] best;

  always_comb begin
    best   = stamps[0];
    victim = '0;
    for (int i = 1; i < WAYS; i++) begin
      if (stamps[i] < best) begin
        best   = stamps[i];
        victim = WAY_W'(i);
      end
    end
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir
  import ctd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int WAYS      = 8,
  parameter int SETS      = 32,
  parameter int STAMP_W   = 24,
  parameter int CNT_W     = 32,
  localparam int OFF_W    = $clog2(BLK_BYTES),
  localparam int SET_W    = $clog2(SETS),
  localparam int TAG_W    = ADDR_W - OFF_W - SET_W,
  localparam int WAY_W    = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        policy_sel,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // directory state
  logic [SETS-1:0][WAYS-1:0]              valid_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]   tag_q;
  logic [SETS-1:0][WAYS-1:0][STAMP_W-1:0] stamp_q;
  logic [SETS-1:0][STAMP_W-1:0]           gen_q;
  logic [SETS-1:0][WAY_W-1:0]             fifo_q;

  // lookup
  logic [SET_W-1:0]   set_idx;
  logic [TAG_W-1:0]   look_tag;
  logic               hit, any_free;
  logic [WAY_W-1:0]   hit_way, free_way, lru_way, sel_way;
  logic [15:0]        rnd;
  policy_e            pol;
  logic               fill_en, stamp_en, fifo_adv;

  assign set_idx  = req_addr[OFF_W +: SET_W];
  assign look_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign pol      = policy_e'(policy_sel);

  ctd_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_ni),
    .chk_en   (req_valid),
    .way_valid(valid_q[set_idx]),
    .way_tag  (tag_q[set_idx]),
    .look_tag (look_tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .any_free (any_free),
    .free_way (free_way)
  );

  ctd_lru_pick #(.WAYS(WAYS), .STAMP_W(STAMP_W)) u_lru (
    .stamps(stamp_q[set_idx]),
    .victim(lru_way)
  );

  ctd_lfsr u_rnd (
    .clk  (clk),
    .rst_n(rst_ni),
    .value(rnd)
  );

  // next-state decisions
  always_comb begin
    if (hit)           sel_way = hit_way;
    else if (any_free) sel_way = free_way;
    else begin
      unique case (pol)
        POL_FIFO: sel_way = fifo_q[set_idx];
        POL_RAND: sel_way = rnd[WAY_W-1:0];
        default:  sel_way = lru_way;
      endcase
    end
    fill_en  = req_valid && !hit;
    stamp_en = req_valid && (pol == POL_LRU || pol == POL_ALT);
    fifo_adv = fill_en && !any_free && (pol == POL_FIFO);
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      stamp_q <= '0;
      gen_q   <= '0;
      fifo_q  <= '0;
    end else begin
      if (fill_en)  valid_q[set_idx][sel_way] <= 1'b1;
      if (stamp_en) begin
        stamp_q[set_idx][sel_way] <= gen_q[set_idx];
        gen_q[set_idx]            <= gen_q[set_idx] + 1'b1;
      end
      if (fifo_adv) fifo_q[set_idx] <= fifo_q[set_idx] + 1'b1;
    end
  end

  // tags are qualified by valid, so they need no reset
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[set_idx][sel_way] <= look_tag;
  end

  // response and totals
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      access_count <= '0;
      miss_count   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= hit;
        rsp_way      <= sel_way;
        access_count <= access_count + 1'b1;
      end
      if (fill_en) miss_count <= miss_count + 1'b1;
    end
  end

  // assertions
  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> !rsp_valid);
  a_r4_free_first: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !hit && any_free) |-> !valid_q[set_idx][sel_way]);
  a_r5_gen_no_wrap: assert property (@(posedge clk) disable iff (!rst_ni)
    stamp_en |-> gen_q[set_idx] != {STAMP_W{1'b1}});
  a_r6_hit_keeps_order: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && hit) |=> $stable(fifo_q));
  a_r8_access_step: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> access_count == CNT_W'($past(access_count) + 1'b1));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !req_valid |=> ($stable(access_count) && $stable(miss_count)));
  a_r8_hit_no_miss: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && hit) |=> $stable(miss_count));
  a_r8_miss_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && !hit) |=> miss_count == CNT_W'($past(miss_count) + 1'b1));
endmodule

// File: tb/cache_tag_dir_tb.sv
module cache_tag_dir_tb;
  localparam int WAY_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  policy_sel = 2'd0;
  logic        rsp_valid, rsp_hit;
  logic [WAY_W-1:0] rsp_way;
  logic [31:0] access_count, miss_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_way = 0;
  int exp_acc = 0;
  int exp_miss = 0;

  always #2.5 clk = ~clk;

  cache_tag_dir u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .policy_sel(policy_sel), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_way(rsp_way), .access_count(access_count), .miss_count(miss_count)
  );

  function automatic logic [31:0] mk(input int t, input int s, input int o);
    logic [31:0] a;
    a = {t[20:0], s[4:0], o[5:0]};
    return a;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one request, then check its response one cycle later; ew<0 skips the way check
  task automatic acc(input int t, input int s, input int o, input bit eh,
                     input int ew, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk(t, s, o);
    @(negedge clk);
    req_valid = 1'b0;
    exp_acc++;
    if (!eh) exp_miss++;
    chk(rsp_valid == 1'b1, "R3", "rsp_valid", rsp_valid, 1);
    chk(rsp_hit == eh, req, $sformatf("hit t=%0d s=%0d", t, s), rsp_hit, eh);
    if (ew >= 0) chk(int'(rsp_way) == ew, req, $sformatf("way t=%0d s=%0d", t, s), rsp_way, ew);
    last_way = int'(rsp_way);
  endtask

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    policy_sel = pol;
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_acc = 0;
    exp_miss = 0;
  endtask

  task automatic chk_counts(input string req);
    chk(access_count == exp_acc, req, "access_count", access_count, exp_acc);
    chk(miss_count == exp_miss, req, "miss_count", miss_count, exp_miss);
  endtask

  task automatic fill_set(input int s);
    for (int i = 0; i < 8; i++) acc(i, s, 0, 1'b0, i, "R4");
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk_counts("R1");
    acc(9, 3, 0, 1'b0, 0, "R1");
  endtask

  task automatic t_split();
    do_reset(2'd0);
    acc(5, 3, 0, 1'b0, 0, "R2");
    acc(5, 3, 63, 1'b1, 0, "R2");
    acc(5, 3, 17, 1'b1, 0, "R2");
    acc(5, 4, 0, 1'b0, 0, "R10");
    acc(6, 3, 0, 1'b0, 1, "R4");
    chk_counts("R8");
  endtask

  task automatic t_lru();
    do_reset(2'd0);
    fill_set(0);
    acc(0, 0, 0, 1'b1, 0, "R5");
    acc(8, 0, 0, 1'b0, 1, "R5");
    acc(9, 0, 0, 1'b0, 2, "R5");
    acc(1, 0, 0, 1'b0, 3, "R5");
    acc(0, 0, 0, 1'b1, 0, "R5");
    acc(7, 5, 0, 1'b0, 0, "R10");
    chk_counts("R8");
    repeat (3) @(negedge clk);
    chk_counts("R8");
  endtask

  task automatic t_fifo();
    do_reset(2'd1);
    fill_set(2);
    acc(0, 2, 0, 1'b1, 0, "R6");
    acc(3, 2, 0, 1'b1, 3, "R6");
    acc(8, 2, 0, 1'b0, 0, "R6");
    acc(9, 2, 0, 1'b0, 1, "R6");
    acc(8, 2, 0, 1'b1, 0, "R6");
    acc(0, 2, 0, 1'b0, 2, "R6");
    chk_counts("R8");
  endtask

  task automatic t_rand();
    int w;
    do_reset(2'd2);
    fill_set(6);
    acc(40, 6, 0, 1'b0, -1, "R7");
    w = last_way;
    acc(40, 6, 0, 1'b1, w, "R7");
    acc(w, 6, 0, 1'b0, -1, "R7");
    chk_counts("R8");
  endtask

  task automatic t_b2b();
    do_reset(2'd0);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = mk(20, 7, 0);
    @(negedge clk);
    chk(rsp_hit == 1'b0, "R9", "first hit", rsp_hit, 0);
    chk(int'(rsp_way) == 0, "R9", "first way", rsp_way, 0);
    req_addr = mk(20, 7, 4);
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R9", "second valid", rsp_valid, 1);
    chk(rsp_hit == 1'b1, "R9", "second hit", rsp_hit, 1);
    req_addr = mk(21, 7, 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_hit == 1'b0, "R9", "third hit", rsp_hit, 0);
    chk(int'(rsp_way) == 1, "R9", "third way", rsp_way, 1);
    exp_acc = 3;
    exp_miss = 2;
    chk_counts("R8");
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog: cycles=%0d expected < %0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_split();
    t_lru();
    t_fifo();
    t_rand();
    t_b2b();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule